// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive and Write-Strobe Control

This block is the device-side control of a 16-bit extended-data-out DRAM, built as a cycle-level model. Each clock edge it samples the active-low strobes: row strobe, one column strobe per byte lane, write enable and output enable. From them it decides, for each byte lane, whether the data pins drive, what data they drive, and when a byte is written. The read data comes from a stub array on `rd_data`. The array, refresh and the analog delays are outside the block. Each delay window is a clock count.

The address and control path uses a merged column strobe. It goes active on the first lane strobe to fall and inactive on the last one to rise. Data handling is separate for each lane. Lane 0 (bits 7:0) follows `cas_n[0]` and lane 1 (bits 15:8) follows `cas_n[1]`. The read output is held through column precharge. Output-enable or write-enable pulses can latch the pins off until the next column fall. A late write made while output enable is low is dropped.

All outputs are registered. Pins sampled at one clock edge show their effect on the outputs just after that same edge.

Top module: `edo_dq_ctrl`

## Requirements
- R1: During reset and after it, with all strobes high, `dq_oe`, `wr_stb` and `cas_act` are 0 and `dq_out` is 0.
- R2: `cas_act` is 1 while at least one lane column strobe is low. It goes 1 on the first lane fall and 0 only after the last lane rise.
- R3: A lane's column strobe falling while the row strobe and write enable are low and high respectively captures that lane's byte of `rd_data` into `dq_out`. Changes to `rd_data` afterwards are ignored. The other lane's byte is unchanged.
- R4: After a lane's column strobe rises, that lane keeps driving its held byte while the row strobe and output enable stay low and write enable stays high.
- R5: With the column strobe low, raising output enable turns the lane off. Lowering it again drives the same held byte.
- R6: If output enable is high when the column strobe rises and stays high for HOLD_CYC sampled cycles (rise cycle included), the lane is latched off until its next column fall, whatever output enable does. A shorter high time latches nothing.
- R7: If output enable goes high after the column rise and stays high for PULSE_CYC cycles while the column strobe is high, the lane is latched off the same way. A shorter pulse latches nothing.
- R8: When the row strobe and the lane's column strobe are both high, the lane stops driving from the next cycle.
- R9: Write enable falling while the column strobe is high latches the lane off. It stays off until the column strobe falls with write enable high.
- R10: Early write: a column fall with write enable already low pulses that lane's `wr_stb` bit for one cycle. The lane stays off for the rest of the cycle whatever output enable does.
- R11: Late write: write enable falling while the column strobe is low and output enable is high pulses `wr_stb` once and turns the lane off.
- R12: Write enable falling while the column strobe is low and output enable is low gives no `wr_stb`, and the lane keeps driving its read byte.
- R13: A column strobe that is already low when the row strobe falls starts no access. `dq_out` keeps the previous cycle's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe per byte lane, bit 0 is the low byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DW | Read word from the stub array |
| dq_oe | output | LANES | Per-lane drive enable for the data pins |
| dq_out | output | DW | Held output data |
| wr_stb | output | LANES | One-cycle per-lane write strobe |
| cas_act | output | 1 | Merged column strobe, active high |

## Verification
The hardest states to reach are the off-latches during column precharge. Whether a latch sets depends on two things: if output enable was high at the moment of the column rise, and how many cycles it then stays high. The stimulus steps output enable one cycle at a time around a column rise. It stops one cycle short of each threshold and then meets it exactly. After that it lowers output enable to show whether the latch took hold. Byte-lane independence is reached by opening one lane's column strobe while the other lane is still latched off. The dropped late write is reached by lowering write enable inside a read while output enable is still low.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;

  // Next-state bundle for one byte lane.
  typedef struct packed {
    logic valid;   // lane holds read data that may be driven
    logic blk;     // lane latched off until next column fall
    logic wrote;   // a write already happened in this column cycle
  } lane_flags_t;

  function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction

endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  output logic             we_fall,
  output logic             cas_act
);

  logic we_prev_q;
  logic cas_act_d, cas_act_q;

  // Merged strobe: active on first lane low, inactive once every lane is high.
  always_comb begin
    cas_act_d = ~(&cas_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      cas_act_q <= 1'b0;
    end else begin
      we_prev_q <= we_n;
      cas_act_q <= cas_act_d;
    end
  end

  assign we_fall = we_prev_q & ~we_n;
  assign cas_act = cas_act_q;

endmodule

// File: rtl/edo_oe_timer.sv
module edo_oe_timer #(
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cas_n,
  input  logic cas_rise,
  input  logic oe_n,
  output logic trip
);
  import edo_dq_pkg::*;

  localparam int MAXT = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam logic [7:0] LIM    = 8'(MAXT);
  localparam logic [7:0] HOLD_W = 8'(HOLD_CYC);
  localparam logic [7:0] PLS_W  = 8'(PULSE_CYC);

  logic [7:0] cnt_q, cnt_d;
  logic       rise_q, rise_d;

  always_comb begin
    cnt_d  = cnt_q;
    rise_d = rise_q;
    if (!cas_n) begin
      cnt_d  = '0;
      rise_d = 1'b0;
    end else if (cas_rise) begin
      rise_d = oe_n;
      cnt_d  = oe_n ? 8'd1 : 8'd0;
    end else if (oe_n) begin
      cnt_d  = sat_inc8(cnt_q, LIM);
    end else begin
      cnt_d  = '0;
      rise_d = 1'b0;
    end
    trip = cas_n & oe_n & (cnt_d >= (rise_d ? HOLD_W : PLS_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rise_q <= rise_d;
    end
  end

endmodule

// File: rtl/edo_lane_ctl.sv
module edo_lane_ctl #(
  parameter int BW        = 8,
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          we_fall,
  input  logic          oe_n,
  input  logic [BW-1:0] rd_byte,
  output logic          drv,
  output logic [BW-1:0] dout,
  output logic          wstb
);
  import edo_dq_pkg::*;

  logic          cas_prev_q;
  lane_flags_t   fl_q, fl_d;
  logic [BW-1:0] dout_q, dout_d;
  logic          drv_q, drv_d;
  logic          wstb_q, wstb_d;
  logic          cas_fall, cas_rise, trip;

  assign cas_fall = cas_prev_q & ~cas_n;
  assign cas_rise = ~cas_prev_q & cas_n;

  edo_oe_timer #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_n    (cas_n),
    .cas_rise (cas_rise),
    .oe_n     (oe_n),
    .trip     (trip)
  );

  always_comb begin
    fl_d   = fl_q;
    dout_d = dout_q;
    wstb_d = 1'b0;
    if (cas_fall && !ras_n) begin
      fl_d.wrote = ~we_n;
      if (we_n) begin
        fl_d.valid = 1'b1;
        fl_d.blk   = 1'b0;
        dout_d     = rd_byte;
      end else begin
        fl_d.valid = 1'b0;
        fl_d.blk   = 1'b1;
        wstb_d     = 1'b1;
      end
    end else if (we_fall) begin
      if (cas_n) begin
        fl_d.blk = 1'b1;
      end else if (!ras_n && !fl_q.wrote && oe_n) begin
        fl_d.blk   = 1'b1;
        fl_d.wrote = 1'b1;
        wstb_d     = 1'b1;
      end
    end
    if (trip) begin
      fl_d.blk = 1'b1;
    end
    if (cas_n && ras_n) begin
      fl_d.valid = 1'b0;
    end
    drv_d = fl_d.valid & ~fl_d.blk & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_prev_q <= 1'b1;
      fl_q       <= '0;
      dout_q     <= '0;
      drv_q      <= 1'b0;
      wstb_q     <= 1'b0;
    end else begin
      cas_prev_q <= cas_n;
      fl_q       <= fl_d;
      dout_q     <= dout_d;
      drv_q      <= drv_d;
      wstb_q     <= wstb_d;
    end
  end

  assign drv  = drv_q;
  assign dout = dout_q;
  assign wstb = wstb_q;

endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl #(
  parameter int DW        = 16,
  parameter int LANES     = 2,
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    rd_data,
  output logic [LANES-1:0] dq_oe,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] wr_stb,
  output logic             cas_act
);

  localparam int BW = DW / LANES;

  logic we_fall;

  edo_pin_sampler #(.LANES(LANES)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .we_fall (we_fall),
    .cas_act (cas_act)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_lane_ctl #(.BW(BW), .HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n[g]),
      .we_n    (we_n),
      .we_fall (we_fall),
      .oe_n    (oe_n),
      .rd_byte (rd_data[g*BW +: BW]),
      .drv     (dq_oe[g]),
      .dout    (dq_out[g*BW +: BW]),
      .wstb    (wr_stb[g])
    );
  end

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [LANES-1:0] dq_oe,
  input logic [LANES-1:0] wr_stb,
  input logic             cas_act
);

  p_cas_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |=> cas_act);

  p_drive_needs_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> $past(!oe_n));

  p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n[0]) |=> !dq_oe[0]);

  p_we_fall_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && cas_n[1]) |=> !dq_oe[1]);

  p_strobe_in_cas_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |-> $past(!cas_n[0]));

  p_write_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[1] |-> !dq_oe[1]);

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .dq_oe   (dq_oe),
  .wr_stb  (wr_stb),
  .cas_act (cas_act)
);

// File: tb/test_edo_dq_ctrl.sv
module test_edo_dq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, we_n, oe_n;
  logic [1:0]  cas_n;
  logic [15:0] rd_data;
  logic [1:0]  dq_oe, wr_stb;
  logic [15:0] dq_out;
  logic        cas_act;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [1:0]  oe;
    logic [15:0] dq;
    bit          chkd;
    logic [1:0]  ws;
    logic        cs;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  edo_dq_ctrl i_edo_dq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .rd_data (rd_data),
    .dq_oe   (dq_oe),
    .dq_out  (dq_out),
    .wr_stb  (wr_stb),
    .cas_act (cas_act)
  );

  // Driver: apply pins on a falling clock edge, queue what must appear after the next rising edge.
  task automatic step(input logic r, input logic [1:0] c, input logic w, input logic o,
                      input logic [15:0] rd, input logic [1:0] e_oe, input logic [15:0] e_dq,
                      input bit cd, input logic [1:0] e_ws, input string tag);
    exp_t e;
    ras_n = r; cas_n = c; we_n = w; oe_n = o; rd_data = rd;
    e.oe = e_oe; e.dq = e_dq; e.chkd = cd; e.ws = e_ws; e.cs = ~(&c); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare one queued item per rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (dq_oe !== e.oe || wr_stb !== e.ws || cas_act !== e.cs ||
            (e.chkd && dq_out !== e.dq)) begin
          errors++;
          $display("FAIL %s: oe=%b ws=%b cas=%b dq=%h expected oe=%b ws=%b cas=%b dq=%h",
                   e.tag, dq_oe, wr_stb, cas_act, dq_out, e.oe, e.ws, e.cs, e.dq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; rd_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (dq_oe !== 2'b00 || wr_stb !== 2'b00 || cas_act !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: oe=%b ws=%b cas=%b expected 00 00 0", dq_oe, wr_stb, cas_act);
    end
    rst_n = 1'b1;
    step(1, 2'b11, 1, 1, 16'h0000, 2'b00, 16'h0000, 1, 2'b00, "R1 idle after reset");
    // Word read, hold, output-enable control
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h0000, 0, 2'b00, "R8 row only");
    step(0, 2'b00, 1, 0, 16'hA55A, 2'b11, 16'hA55A, 1, 2'b00, "R3 word capture");
    step(0, 2'b00, 1, 0, 16'hFFFF, 2'b11, 16'hA55A, 1, 2'b00, "R3 late data ignored");
    step(0, 2'b00, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R5 oe high off");
    step(0, 2'b00, 1, 0, 16'hFFFF, 2'b11, 16'hA55A, 1, 2'b00, "R5 oe low redrive");
    step(0, 2'b11, 1, 0, 16'hFFFF, 2'b11, 16'hA55A, 1, 2'b00, "R4 hold after rise");
    step(0, 2'b11, 1, 0, 16'hFFFF, 2'b11, 16'hA55A, 1, 2'b00, "R4 hold continues");
    step(0, 2'b11, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 pulse 1");
    step(0, 2'b11, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 pulse 2");
    step(0, 2'b11, 1, 0, 16'hFFFF, 2'b11, 16'hA55A, 1, 2'b00, "R7 short pulse no latch");
    step(0, 2'b11, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 pulse a");
    step(0, 2'b11, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 pulse b");
    step(0, 2'b11, 1, 1, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 pulse c");
    step(0, 2'b11, 1, 0, 16'hFFFF, 2'b00, 16'hA55A, 0, 2'b00, "R7 latched off");
    step(0, 2'b10, 1, 0, 16'h1234, 2'b01, 16'hA534, 1, 2'b00, "R3 low lane only");
    step(0, 2'b00, 1, 0, 16'h5678, 2'b11, 16'h5634, 1, 2'b00, "R3 high lane capture");
    step(0, 2'b01, 1, 0, 16'h0000, 2'b11, 16'h5634, 1, 2'b00, "R2 one lane still low");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b11, 16'h5634, 1, 2'b00, "R2 last lane rise");
    // Hold window at rise
    step(0, 2'b00, 1, 0, 16'h9ABC, 2'b11, 16'h9ABC, 1, 2'b00, "R3 capture 9ABC");
    step(0, 2'b00, 1, 1, 16'h0000, 2'b00, 16'h9ABC, 0, 2'b00, "R5 off");
    step(0, 2'b11, 1, 1, 16'h0000, 2'b00, 16'h9ABC, 0, 2'b00, "R6 rise oe high");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b11, 16'h9ABC, 1, 2'b00, "R6 short hold no latch");
    step(0, 2'b00, 1, 1, 16'h1111, 2'b00, 16'h1111, 1, 2'b00, "R3 capture oe high");
    step(0, 2'b11, 1, 1, 16'h0000, 2'b00, 16'h1111, 0, 2'b00, "R6 rise oe high");
    step(0, 2'b11, 1, 1, 16'h0000, 2'b00, 16'h1111, 0, 2'b00, "R6 hold met");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h1111, 1, 2'b00, "R6 latched off");
    step(1, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h1111, 0, 2'b00, "R8 row high");
    // Row and column both high
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h1111, 0, 2'b00, "R8 row low");
    step(0, 2'b00, 1, 0, 16'h2222, 2'b11, 16'h2222, 1, 2'b00, "R3 capture 2222");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b11, 16'h2222, 1, 2'b00, "R4 hold");
    step(1, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h2222, 0, 2'b00, "R8 both high off");
    // Column before row
    step(1, 2'b00, 1, 0, 16'h3333, 2'b00, 16'h2222, 1, 2'b00, "R13 column first");
    step(0, 2'b00, 1, 0, 16'h4444, 2'b00, 16'h2222, 1, 2'b00, "R13 data kept");
    step(0, 2'b11, 1, 0, 16'h4444, 2'b00, 16'h2222, 1, 2'b00, "R13 precharge");
    step(0, 2'b00, 1, 0, 16'h4444, 2'b11, 16'h4444, 1, 2'b00, "R3 capture 4444");
    // Write enable paths
    step(0, 2'b00, 0, 0, 16'h0000, 2'b11, 16'h4444, 1, 2'b00, "R12 late write dropped");
    step(0, 2'b00, 1, 0, 16'h0000, 2'b11, 16'h4444, 1, 2'b00, "R12 still driving");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b11, 16'h4444, 1, 2'b00, "R4 hold");
    step(0, 2'b11, 0, 0, 16'h0000, 2'b00, 16'h4444, 0, 2'b00, "R9 we fall off");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h4444, 0, 2'b00, "R9 stays off");
    step(0, 2'b00, 1, 0, 16'h5555, 2'b11, 16'h5555, 1, 2'b00, "R9 released by read");
    step(0, 2'b00, 1, 1, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R11 oe high");
    step(0, 2'b00, 0, 1, 16'h0000, 2'b00, 16'h5555, 0, 2'b11, "R11 late write strobe");
    step(0, 2'b00, 0, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R11 single strobe off");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R11 off in precharge");
    step(0, 2'b11, 0, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R9 we low");
    step(0, 2'b00, 0, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b11, "R10 early write strobe");
    step(0, 2'b00, 0, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R10 off whatever oe");
    step(0, 2'b11, 0, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R10 precharge");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h5555, 0, 2'b00, "R9 we high still off");
    step(0, 2'b10, 1, 0, 16'h6677, 2'b01, 16'h5577, 1, 2'b00, "R3 low lane read");
    step(0, 2'b11, 1, 0, 16'h0000, 2'b01, 16'h5577, 1, 2'b00, "R4 low lane hold");
    step(1, 2'b11, 1, 0, 16'h0000, 2'b00, 16'h5577, 1, 2'b00, "R8 off");
    step(0, 2'b11, 0, 0, 16'h0000, 2'b00, 16'h5577, 1, 2'b00, "R9 we low");
    step(0, 2'b01, 0, 0, 16'h0000, 2'b00, 16'h5577, 1, 2'b10, "R10 high byte write");
    step(1, 2'b11, 1, 1, 16'h0000, 2'b00, 16'h5577, 1, 2'b00, "R1 back to idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule